// File: doc/BRIEF.md
# Manchester-coded fieldbus frame serializer

This block turns one fieldbus frame into a Manchester-coded line signal when a start strobe arrives. On an accepted start it takes a snapshot of a control byte, a bank of 32-bit payload words and a payload byte count. It then drives, one half-bit at a time, a start delimiter, the control byte, the payload bytes, a 16-bit check sequence that it computes itself, and an end delimiter. The delimiters contain code violations, so a receiver cannot mistake them for data.

Every bit is sent as two half-bits. Each half-bit lasts a parameterised number of system clock cycles. At 100 MHz the default of 1600 cycles gives the slowest rate of 31.25 kbit/s. After a complete frame the block raises a done flag. A session counter runs only on the system clock. If a frame is still running when that counter saturates, the counter drops the frame and returns the block to idle without raising done.

Top module: `mfs_frame_serializer`

## Requirements
- R1: After reset, `line_o`, `line_en_o` and `done_o` are all 0.
- R2: A start accepted in idle takes a snapshot of `ctrl_i`, `payload_i` and `nbytes_i`. Changes to those inputs during the frame do not alter the frame.
- R3: Each bit is a pair of half-bits, first half first, each half lasting `HALF_TICKS` cycles. Encodings: one = 10, zero = 01, violation-plus = 11, violation-minus = 00. The first half-bit appears in the cycle after the start edge.
- R4: The frame order is: start delimiter, control byte, payload bytes, check sequence, end delimiter. The start delimiter is the 32 half-bits 0x9999B24D and the end delimiter is the 16 half-bits 0xB32C, both sent from the most significant bit.
- R5: Payload byte k (from 0) is `payload_i[8k+7:8k]`. Bytes go out in increasing k, each byte most significant bit first. A count of 0 sends no payload bytes.
- R6: A count above `4*NUM_WORDS` is treated as `4*NUM_WORDS`.
- R7: The check sequence uses polynomial 0x1021 and starts at 0xFFFF. It runs over the control and payload bits in the order they are sent. It is sent inverted, most significant bit first.
- R8: `line_en_o` is 1 exactly for the cycles of the frame. `line_o` is 0 whenever `line_en_o` is 0.
- R9: `done_o` rises in the cycle after the last end-delimiter half-bit ends. It stays at 1 until the next accepted start clears it.
- R10: A start strobe while a frame is in progress is ignored.
- R11: The session counter clears on an accepted start and counts each frame cycle. A frame longer than 2^`SESS_W` cycles is dropped after 2^`SESS_W` cycles, with `done_o` left at 0. A frame of exactly 2^`SESS_W` cycles completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe |
| ctrl_i | input | 8 | Control byte |
| payload_i | input | 32*NUM_WORDS | Payload words, byte k at bits 8k+7:8k |
| nbytes_i | input | CNT_W | Payload byte count |
| line_o | output | 1 | Manchester half-bit stream |
| line_en_o | output | 1 | Line driver enable, high during a frame |
| done_o | output | 1 | Frame completed successfully |

## Verification
The bench compares the line, the enable and the done flag on every cycle against a model of half-bit queues. It targets several corner cases:
- A frame that ends exactly when the session counter saturates must complete. A design that gave the timeout priority would drop it and never raise done.
- A frame one byte longer must be dropped. A design that stopped the counter or compared off by one would let it finish.
- Inputs are changed, and start is pulsed again, in the middle of a frame. A design that read through to the inputs or restarted on the strobe would corrupt the bit stream.
- An empty payload and an oversized count are also sent. These expose a check sequence that misses the control byte and a byte index that runs past the bank.

// File: rtl/mfs_pkg.sv
package mfs_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_SOF,
      S_DATA,
      S_CRC,
      S_EOF
   } ser_state_e;

   // Half-bit images of the delimiters, most significant half-bit first.
   // ONE=10 ZERO=01 VPLUS=11 VMINUS=00
   localparam logic [31:0] SOF_HALVES = 32'h9999_B24D;
   localparam logic [15:0] EOF_HALVES = 16'hB32C;

endpackage

// File: rtl/mfs_half_timer.sv
module mfs_half_timer #(
   parameter int HALF_TICKS = 1600
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic run_i,
   output logic half_end_o
);
   localparam int TW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
   localparam logic [TW-1:0] LAST = TW'(HALF_TICKS - 1);

   logic [TW-1:0] cnt_q;

   generate
      if (HALF_TICKS < 2) begin : g_bad_ticks
         $error("HALF_TICKS must be at least 2");
      end
   endgenerate

   assign half_end_o = run_i && (cnt_q == LAST);

   always_ff @(posedge clk_i) begin
      if (!rst_ni || !run_i || half_end_o) cnt_q <= '0;
      else                                 cnt_q <= cnt_q + 1'b1;
   end

   a_r3_tick_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
      half_end_o |=> (cnt_q == '0));

endmodule

// File: rtl/mfs_crc16.sv
module mfs_crc16 #(
   parameter logic [15:0] POLY = 16'h1021,
   parameter logic [15:0] INIT = 16'hFFFF
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        clr_i,
   input  logic        en_i,
   input  logic        bit_i,
   output logic [15:0] crc_o
);
   logic fb;
   assign fb = crc_o[15] ^ bit_i;

   always_ff @(posedge clk_i) begin
      if (!rst_ni || clr_i) crc_o <= INIT;
      else if (en_i)        crc_o <= {crc_o[14:0], 1'b0} ^ (fb ? POLY : 16'h0000);
   end

   a_r7_crc_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (crc_o == INIT));

endmodule

// File: rtl/mfs_frame_serializer.sv
module mfs_frame_serializer
   import mfs_pkg::*;
#(
   parameter int          NUM_WORDS  = 67,
   parameter int          HALF_TICKS = 1600,
   parameter int          CNT_W      = 9,
   parameter int          SESS_W     = 23,
   parameter logic [15:0] CRC_POLY   = 16'h1021,
   parameter logic [15:0] CRC_INIT   = 16'hFFFF
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    start_i,
   input  logic [7:0]              ctrl_i,
   input  logic [32*NUM_WORDS-1:0] payload_i,
   input  logic [CNT_W-1:0]        nbytes_i,
   output logic                    line_o,
   output logic                    line_en_o,
   output logic                    done_o
);
   localparam int MAX_BYTES = NUM_WORDS * 4;
   localparam int PAY_W     = MAX_BYTES * 8;
   localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_BYTES);

   generate
      if ((2 ** CNT_W) <= MAX_BYTES) begin : g_bad_cnt
         $error("CNT_W too narrow for 4*NUM_WORDS");
      end
      if (SESS_W < 4) begin : g_bad_sess
         $error("SESS_W must be at least 4");
      end
   endgenerate

   ser_state_e        state_q;
   logic [4:0]        pos_q;
   logic [CNT_W-1:0]  byte_q;
   logic [CNT_W-1:0]  n_q;
   logic [7:0]        ctrl_q;
   logic [PAY_W-1:0]  pay_q;
   logic [SESS_W-1:0] sess_q;
   logic              done_q;

   logic              busy, half_end, start_acc, last_half, sess_max;
   logic              cur_bit, crc_en, line_c;
   logic [15:0]       crc_q;
   logic [7:0]        byte_arr [0:MAX_BYTES];

   assign busy      = (state_q != S_IDLE);
   assign start_acc = !busy && start_i;
   assign last_half = half_end && (state_q == S_EOF) && (pos_q == 5'd15);
   assign sess_max  = &sess_q;

   mfs_half_timer #(.HALF_TICKS(HALF_TICKS)) u_timer (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .run_i      (busy),
      .half_end_o (half_end)
   );

   // Byte 0 of the stream is the control byte, then the payload bytes.
   assign byte_arr[0] = ctrl_q;
   generate
      for (genvar k = 1; k <= MAX_BYTES; k++) begin : g_unpack
         assign byte_arr[k] = pay_q[8*(k-1) +: 8];
      end
   endgenerate

   assign cur_bit = byte_arr[byte_q][3'd7 - pos_q[3:1]];
   assign crc_en  = (state_q == S_DATA) && half_end && pos_q[0];

   mfs_crc16 #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (start_acc),
      .en_i   (crc_en),
      .bit_i  (cur_bit),
      .crc_o  (crc_q)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         state_q <= S_IDLE;
         pos_q   <= '0;
         byte_q  <= '0;
         n_q     <= '0;
         ctrl_q  <= '0;
         pay_q   <= '0;
         sess_q  <= '0;
         done_q  <= 1'b0;
      end else if (start_acc) begin
         state_q <= S_SOF;
         pos_q   <= '0;
         byte_q  <= '0;
         n_q     <= (nbytes_i > MAX_CNT) ? MAX_CNT : nbytes_i;
         ctrl_q  <= ctrl_i;
         pay_q   <= payload_i;
         sess_q  <= '0;
         done_q  <= 1'b0;
      end else if (busy) begin
         sess_q <= sess_q + 1'b1;
         if (last_half) begin
            state_q <= S_IDLE;
            done_q  <= 1'b1;
         end else if (sess_max) begin
            state_q <= S_IDLE;
         end else if (half_end) begin
            pos_q <= pos_q + 5'd1;
            unique case (state_q)
               S_SOF: if (pos_q == 5'd31) begin
                  state_q <= S_DATA;
                  pos_q   <= '0;
               end
               S_DATA: if (pos_q == 5'd15) begin
                  pos_q <= '0;
                  if (byte_q == n_q) state_q <= S_CRC;
                  else               byte_q  <= byte_q + 1'b1;
               end
               S_CRC: if (pos_q == 5'd31) begin
                  state_q <= S_EOF;
                  pos_q   <= '0;
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      unique case (state_q)
         S_SOF:   line_c = SOF_HALVES[5'd31 - pos_q];
         S_DATA:  line_c = cur_bit ^ pos_q[0];
         S_CRC:   line_c = ~crc_q[4'd15 - pos_q[4:1]] ^ pos_q[0];
         S_EOF:   line_c = EOF_HALVES[4'd15 - pos_q[3:0]];
         default: line_c = 1'b0;
      endcase
   end

   assign line_o    = line_c;
   assign line_en_o = busy;
   assign done_o    = done_q;

   a_r8_idle_line_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !line_en_o |-> !line_o);

   a_r9_done_after_eof: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(done_o) |-> $past(state_q == S_EOF));

   a_r10_busy_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy && start_i) |=> ($stable(ctrl_q) && $stable(n_q)));

   a_r11_session_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_acc |=> ((sess_q == '0) && (state_q == S_SOF)));

   a_r4_crc_after_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((state_q == S_DATA) && half_end && (pos_q == 5'd15) && (byte_q == n_q))
      |=> ((state_q == S_CRC) || (state_q == S_IDLE)));

endmodule

// File: tb/mfs_frame_serializer_tb_top.sv
module mfs_frame_serializer_tb_top;
   localparam int NW   = 3;
   localparam int HT   = 4;
   localparam int SW   = 10;
   localparam int MAXB = NW * 4;

   logic          clk = 0;
   logic          rst_n = 0;
   logic          start = 0;
   logic [7:0]    ctrl = 0;
   logic [32*NW-1:0] payload = '0;
   logic [8:0]    nbytes = 0;
   logic          line, line_en, done;

   int checks = 0, errors = 0, mism = 0, cyc_total = 0;

   always #4 clk = ~clk;

   mfs_frame_serializer #(.NUM_WORDS(NW), .HALF_TICKS(HT), .CNT_W(9), .SESS_W(SW)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .ctrl_i(ctrl),
      .payload_i(payload), .nbytes_i(nbytes),
      .line_o(line), .line_en_o(line_en), .done_o(done));

   // ---------------- reference model ----------------
   bit seq[$];
   int sect[$];
   bit busy_m = 0, done_m = 0;
   int cyc = 0, flen = 0;

   task automatic push_halves(input logic [31:0] pat, input int n, input int s);
      for (int i = n - 1; i >= 0; i--) begin seq.push_back(pat[i]); sect.push_back(s); end
   endtask

   task automatic push_bit(input bit b, input int s);
      seq.push_back(b); seq.push_back(!b); sect.push_back(s); sect.push_back(s);
   endtask

   task automatic build_frame();
      logic [15:0] crc;
      int eff;
      byte unsigned stream[$];
      seq.delete(); sect.delete();
      eff = (nbytes > MAXB) ? MAXB : int'(nbytes);
      stream.push_back(ctrl);
      for (int k = 0; k < eff; k++) stream.push_back(payload[8*k +: 8]);
      push_halves(32'h9999B24D, 32, 0);
      crc = 16'hFFFF;
      foreach (stream[i]) begin
         for (int b = 7; b >= 0; b--) begin
            bit v = stream[i][b];
            bit fb = crc[15] ^ v;
            push_bit(v, 1);
            crc = {crc[14:0], 1'b0};
            if (fb) crc = crc ^ 16'h1021;
         end
      end
      for (int b = 15; b >= 0; b--) push_bit(!crc[b], 2);
      push_halves(32'h0000B32C, 16, 3);
      flen = seq.size() * HT;
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         busy_m = 0; done_m = 0; cyc = 0;
      end else if (busy_m) begin
         if (cyc + 1 == flen) begin busy_m = 0; done_m = 1; end
         else if (cyc + 1 == (1 << SW)) busy_m = 0;
         else cyc = cyc + 1;
      end else if (start) begin
         build_frame();
         busy_m = 1; cyc = 0; done_m = 0;
      end
   end

   function automatic string tag_of(input int s);
      case (s)
         1: return "R5";
         2: return "R7";
         default: return "R4";
      endcase
   endfunction

   always @(negedge clk) begin
      cyc_total++;
      if (cyc_total > 150000) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
      if (rst_n) begin
         bit el;
         el = busy_m ? seq[cyc / HT] : 1'b0;
         checks += 3;
         if (line_en !== busy_m) begin
            errors++; mism++;
            $display("FAIL R8 line_en actual=%0b expected=%0b", line_en, busy_m);
         end
         if (line !== el) begin
            errors++; mism++;
            $display("FAIL %s R3 line half %0d actual=%0b expected=%0b",
                     busy_m ? tag_of(sect[cyc / HT]) : "R8", cyc / HT, line, el);
         end
         if (done !== done_m) begin
            errors++; mism++;
            $display("FAIL R9 done actual=%0b expected=%0b", done, done_m);
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic run_frame(input logic [7:0] c, input int nb, input int seed,
                            input bit disturb, input string tag);
      int m0, eff;
      bit exp_done;
      m0 = mism;
      @(negedge clk);
      ctrl = c; nbytes = 9'(nb);
      for (int k = 0; k < MAXB; k++) payload[8*k +: 8] = 8'(seed + 37 * k);
      start = 1;
      @(negedge clk);
      start = 0;
      if (disturb) begin
         repeat (20) @(negedge clk);
         payload = ~payload; ctrl = ~ctrl; nbytes = 9'd1; start = 1;
         @(negedge clk);
         start = 0;
         repeat (150) @(negedge clk);
         start = 1;
         @(negedge clk);
         start = 0;
      end
      while (busy_m) @(negedge clk);
      eff = (nb > MAXB) ? MAXB : nb;
      exp_done = ((16 * eff + 96) * HT) <= (1 << SW);
      check({tag, " done at frame end"}, int'(done), int'(exp_done));
      check({tag, " cycle mismatches in frame"}, mism - m0, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R1 line after reset", int'(line), 0);
      check("R1 line_en after reset", int'(line_en), 0);
      check("R1 done after reset", int'(done), 0);
      rst_n = 1;
      @(negedge clk);
      run_frame(8'h5A, 3, 11, 1'b1, "R2 R10 snapshot and busy start");
      repeat (5) @(negedge clk);
      check("R9 done held while idle", int'(done), 1);
      run_frame(8'hC3, 0, 0, 1'b0, "R5 R7 empty payload");
      run_frame(8'h00, 5, 200, 1'b0, "R3 R4 five bytes");
      run_frame(8'hFF, 10, 77, 1'b0, "R11 frame at session limit");
      run_frame(8'h81, 11, 5, 1'b0, "R11 frame over session limit");
      check("R11 line idle after drop", int'(line_en), 0);
      run_frame(8'h3C, 20, 99, 1'b0, "R6 oversized count");
      run_frame(8'h96, 2, 150, 1'b0, "R9 recovery after drop");
      repeat (4) @(negedge clk);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule